// File: doc/BRIEF.md
# NMI Edge Detector with Standby Wake

This block turns the raw non-maskable interrupt pin into a latched event flag. It also generates wake requests for two low-power states. The pin passes through a synchronizer. A polarity input selects whether a falling or a rising edge counts as an event. A detected edge sets a flag that software clears by writing one to a clear strobe. The flag is forwarded as an interrupt request only while the mask register is 0, and the mask register comes out of reset at 1.

Two standby indicators and a clock-running indicator come from the power controller.

- **Light standby:** the mask decides whether an edge may wake the device. While the clock is stopped and the mask is 1, the edge reference is frozen. A pulse that returns to its idle level before the clock restarts is lost. A level that is still at its post-edge value when the clock restarts is seen as an edge at that moment.
- **Deep standby:** any selected edge wakes the device, whatever the mask. The power-on reset that follows deep standby returns the mask to 1.

Top module: `nmi_wake_ctl`

## Requirements
- R1: During and after reset, nmi_flag is 0, nmi_mask is 1, and nmi_req, wake_light and wake_deep are 0.
- R2: With edge_rise at 0 only a high-to-low pin transition sets nmi_flag, and with edge_rise at 1 only a low-to-high transition does. The opposite transition leaves the flag at 0. With the clock running, the flag is 1 after the third rising clock edge that follows the pin change.
- R3: A one-cycle pulse on flag_clr clears nmi_flag at the next clock edge. If a detected edge and flag_clr fall on the same cycle, the flag ends up 1.
- R4: nmi_req is 1 exactly when nmi_flag is 1 and nmi_mask is 0.
- R5: In light standby with the mask at 0, a selected edge sets wake_light and nmi_flag. wake_light stays 1 until stby_light returns to 0, and is 0 one clock after that.
- R6: In light standby with the mask at 1 and clk_run at 0, wake_light stays 0. An edge pulse that returns to the idle level before clk_run returns to 1 leaves nmi_flag at 0 after the clock restarts.
- R7: If the pin still holds its post-edge level when clk_run returns to 1 after masked light standby, nmi_flag is 1 after the next clock edge. nmi_req stays 0 while the mask is 1 and becomes 1 once the mask is written 0.
- R8: In deep standby a selected edge sets wake_deep whatever the mask value. wake_deep stays 1 until stby_deep returns to 0.
- R9: A mask_we pulse loads mask_wd into nmi_mask at the next clock edge. A reset returns nmi_mask to 1 whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| nmi_pin | input | 1 | Raw interrupt pin, asynchronous |
| edge_rise | input | 1 | Edge select: 0 falling, 1 rising |
| mask_we | input | 1 | Mask register write strobe |
| mask_wd | input | 1 | Mask write data (1 = masked) |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| stby_light | input | 1 | Device is in light standby |
| stby_deep | input | 1 | Device is in deep standby |
| clk_run | input | 1 | Main clock is running |
| nmi_req | output | 1 | Interrupt request to the CPU |
| nmi_flag | output | 1 | Latched edge flag |
| nmi_mask | output | 1 | Current mask register value |
| wake_light | output | 1 | Wake request out of light standby |
| wake_deep | output | 1 | Wake request out of deep standby |

## Verification
A frozen or wrongly updated edge reference is the most likely internal fault. It shows at nmi_flag within three clocks of a pin change: a flag that fails to set for the selected edge, or one that sets for the opposite edge. When the fault is a reference that keeps updating during masked standby, it shows when the clock restarts, either as a lost held-level edge or as a flag raised by a pulse that should have been lost. A wrongly armed wake path shows at wake_light or wake_deep three clocks after the pin change while the matching standby indicator is high.

// File: rtl/nmi_wake_pkg.sv
// Package: shared types and constants for the NMI wake controller.
// Assumes: single always-on clock domain for all logic in the block.
package nmi_wake_pkg;
    // Edge polarity select encoding.
    typedef enum logic {
        POL_FALL = 1'b0,
        POL_RISE = 1'b1
    } nmi_pol_e;

    // Index of each standby mode in the wake vector.
    localparam int unsigned WK_LIGHT = 0;
    localparam int unsigned WK_DEEP  = 1;
    localparam int unsigned WK_MODES = 2;
endpackage

// File: rtl/nmi_sync.sv
// Module: nmi_sync
// Brings the asynchronous pin into the clock domain through a chain of
// STAGES flops. Assumes the chain runs on the always-on clock, so it keeps
// sampling while the main clock is stopped.
module nmi_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: capture the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= RST_VAL;
                    else        chain_q[g] <= din;
                end
            end else begin : g_next
                // Later stages: shift the previous stage along.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= RST_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_edge_det.sv
// Module: nmi_edge_det
// Compares the synchronized pin with a reference level. The reference
// follows the pin only while detection is live, so a level that changed
// while detection was frozen appears as an edge once it is live again.
// Assumes live is high whenever the main clock runs.
module nmi_edge_det
    import nmi_wake_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin_s,
    input  nmi_pol_e pol,
    input  logic     live,
    output logic     pend,
    output logic     edge_evt
);
    logic ref_q;

    // Pending: the pin differs from the reference in the selected direction.
    always_comb begin
        if (pol == POL_RISE) pend = pin_s & ~ref_q;
        else                 pend = ~pin_s & ref_q;
    end

    assign edge_evt = pend & live;

    // Reference level: follow the pin while live, hold while frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)    ref_q <= IDLE_LEVEL;
        else if (live) ref_q <= pin_s;
    end

    AST_REF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> $stable(ref_q)); // R6
endmodule

// File: rtl/nmi_flag_mask.sv
// Module: nmi_flag_mask
// Holds the edge flag (set on event, write-one-to-clear, set wins) and
// the mask register (reset value 1). Assumes software checks that the flag
// is clear before it writes 0 to the mask.
module nmi_flag_mask (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_evt,
    input  logic flag_clr,
    input  logic mask_we,
    input  logic mask_wd,
    output logic flag_q,
    output logic mask_q
);
    // Flag register: a set takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (edge_evt) flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    // Mask register: loaded by write strobe, masked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= 1'b1;
        else if (mask_we) mask_q <= mask_wd;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        edge_evt |=> flag_q); // R3
    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !edge_evt) |=> !flag_q); // R3
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(mask_wd))); // R9
endmodule

// File: rtl/nmi_wake_gen.sv
// Module: nmi_wake_gen
// One sticky wake request per standby mode. Light standby is armed only
// while the mask is 0; deep standby is always armed. A request clears when
// its standby indicator drops. Assumes the standby indicators are stable
// for the whole standby period.
module nmi_wake_gen
    import nmi_wake_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pend,
    input  logic                mask_q,
    input  logic [WK_MODES-1:0] stby,
    output logic [WK_MODES-1:0] wake_q
);
    logic [WK_MODES-1:0] arm;

    // Arming per mode: light follows the mask, deep ignores it.
    always_comb begin
        arm           = '1;
        arm[WK_LIGHT] = ~mask_q;
    end

    genvar m;
    generate
        for (m = 0; m < WK_MODES; m++) begin : g_mode
            // Sticky wake: set by an armed pending edge in standby.
            always_ff @(posedge clk) begin
                if (!rst_n || !stby[m]) wake_q[m] <= 1'b0;
                else if (arm[m] && pend) wake_q[m] <= 1'b1;
            end

            AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (stby[m] && wake_q[m]) |=> wake_q[m]); // R5
        end
    endgenerate

    AST_NO_MASKED_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q && !wake_q[WK_LIGHT]) |=> !wake_q[WK_LIGHT]); // R6
    AST_DEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (stby[WK_DEEP] && pend) |=> wake_q[WK_DEEP]); // R8
endmodule

// File: rtl/nmi_wake_ctl.sv
// Module: nmi_wake_ctl (top)
// NMI edge detection with a latched flag, a mask gating the request, and
// wake requests for light and deep standby. Assumes clk is an always-on
// clock and clk_run reports whether the main clock is running.
module nmi_wake_ctl
    import nmi_wake_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic        IDLE_LEVEL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_pin,
    input  logic edge_rise,
    input  logic mask_we,
    input  logic mask_wd,
    input  logic flag_clr,
    input  logic stby_light,
    input  logic stby_deep,
    input  logic clk_run,
    output logic nmi_req,
    output logic nmi_flag,
    output logic nmi_mask,
    output logic wake_light,
    output logic wake_deep
);
    logic                pin_s;
    logic                pend;
    logic                edge_evt;
    logic                live;
    logic                flag_q;
    logic                mask_q;
    logic [WK_MODES-1:0] stby_vec;
    logic [WK_MODES-1:0] wake_vec;
    nmi_pol_e            pol;

    assign pol = nmi_pol_e'(edge_rise);

    // Detection is live with the clock running, when unmasked, or in deep standby.
    assign live = clk_run | ~mask_q | stby_deep;

    assign stby_vec[WK_LIGHT] = stby_light;
    assign stby_vec[WK_DEEP]  = stby_deep;

    nmi_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IDLE_LEVEL)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (nmi_pin),
        .dout  (pin_s)
    );

    nmi_edge_det #(
        .IDLE_LEVEL (IDLE_LEVEL)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_s    (pin_s),
        .pol      (pol),
        .live     (live),
        .pend     (pend),
        .edge_evt (edge_evt)
    );

    nmi_flag_mask u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_evt (edge_evt),
        .flag_clr (flag_clr),
        .mask_we  (mask_we),
        .mask_wd  (mask_wd),
        .flag_q   (flag_q),
        .mask_q   (mask_q)
    );

    nmi_wake_gen u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (pend),
        .mask_q (mask_q),
        .stby   (stby_vec),
        .wake_q (wake_vec)
    );

    assign nmi_flag   = flag_q;
    assign nmi_mask   = mask_q;
    assign nmi_req    = flag_q & ~mask_q;
    assign wake_light = wake_vec[WK_LIGHT];
    assign wake_deep  = wake_vec[WK_DEEP];
endmodule

// File: tb/sim_nmi_wake_ctl.sv
module sim_nmi_wake_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi_pin = 1'b1;
    logic edge_rise = 1'b0;
    logic mask_we = 1'b0;
    logic mask_wd = 1'b0;
    logic flag_clr = 1'b0;
    logic stby_light = 1'b0;
    logic stby_deep = 1'b0;
    logic clk_run = 1'b1;
    logic nmi_req, nmi_flag, nmi_mask, wake_light, wake_deep;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;  // 250 MHz

    nmi_wake_ctl u0 (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .edge_rise(edge_rise),
        .mask_we(mask_we), .mask_wd(mask_wd), .flag_clr(flag_clr),
        .stby_light(stby_light), .stby_deep(stby_deep), .clk_run(clk_run),
        .nmi_req(nmi_req), .nmi_flag(nmi_flag), .nmi_mask(nmi_mask),
        .wake_light(wake_light), .wake_deep(wake_deep)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Wait n rising edges, then sample 1 ns later (inputs change on falling edges).
    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drv;
        @(negedge clk);
    endtask

    task automatic write_mask(input logic v);
        drv(); mask_we = 1'b1; mask_wd = v;
        drv(); mask_we = 1'b0;
    endtask

    task automatic clear_flag;
        drv(); flag_clr = 1'b1;
        drv(); flag_clr = 1'b0;
    endtask

    task automatic do_reset;
        drv(); rst_n = 1'b0;
        cyc(3);
        drv(); rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        cyc(2);
        // R1: outputs during reset
        chk("R1 flag in reset", nmi_flag, 1'b0);
        chk("R1 mask in reset", nmi_mask, 1'b1);
        drv(); rst_n = 1'b1;
        cyc(2);
        chk("R1 flag", nmi_flag, 1'b0);
        chk("R1 mask", nmi_mask, 1'b1);
        chk("R1 req", nmi_req, 1'b0);
        chk("R1 wake_light", wake_light, 1'b0);
        chk("R1 wake_deep", wake_deep, 1'b0);

        // R2 / R4: sweep polarity x transition x mask; flag = transition matches polarity
        for (int pol = 0; pol < 2; pol++) begin
            for (int dir = 0; dir < 2; dir++) begin
                for (int mk = 0; mk < 2; mk++) begin
                    // dir 0: high->low, dir 1: low->high
                    drv(); edge_rise = pol[0]; nmi_pin = ~dir[0];
                    cyc(5);
                    clear_flag();
                    write_mask(mk[0]);
                    drv(); nmi_pin = dir[0];
                    cyc(2);
                    chk("R2 flag not yet set after two edges", nmi_flag, 1'b0);
                    cyc(1);
                    chk("R2 flag after third edge", nmi_flag, (pol == dir) ? 1'b1 : 1'b0);
                    chk("R4 req gating", nmi_req, ((pol == dir) && mk == 0) ? 1'b1 : 1'b0);
                    clear_flag();
                    cyc(1);
                    chk("R3 flag cleared", nmi_flag, 1'b0);
                end
            end
        end

        // R3: set and clear in the same cycle; set wins
        drv(); edge_rise = 1'b0; nmi_pin = 1'b1;
        cyc(5);
        drv(); nmi_pin = 1'b0;   // flag sets at the third edge
        cyc(3);
        clear_flag();
        drv(); nmi_pin = 1'b1;
        cyc(5);
        drv(); nmi_pin = 1'b0;   // pin changes before edge 1
        @(posedge clk); @(posedge clk);
        @(negedge clk); flag_clr = 1'b1;  // clear in the cycle of edge 3
        @(negedge clk); flag_clr = 1'b0;
        #1;
        chk("R3 set wins over clear", nmi_flag, 1'b1);
        clear_flag();
        drv(); nmi_pin = 1'b1;
        cyc(5);

        // R5: light standby, unmasked
        write_mask(1'b0);
        drv(); stby_light = 1'b1; clk_run = 1'b0;
        cyc(2);
        chk("R5 no wake before edge", wake_light, 1'b0);
        drv(); nmi_pin = 1'b0;
        cyc(4);
        chk("R5 wake_light", wake_light, 1'b1);
        chk("R5 flag", nmi_flag, 1'b1);
        drv(); nmi_pin = 1'b1;
        cyc(4);
        chk("R5 wake held", wake_light, 1'b1);
        drv(); stby_light = 1'b0; clk_run = 1'b1;
        cyc(1);
        chk("R5 wake cleared on exit", wake_light, 1'b0);
        clear_flag();

        // R6: light standby, masked, pulse lost
        write_mask(1'b1);
        drv(); stby_light = 1'b1; clk_run = 1'b0;
        drv(); nmi_pin = 1'b0;
        cyc(5);
        chk("R6 no wake when masked", wake_light, 1'b0);
        drv(); nmi_pin = 1'b1;
        cyc(5);
        drv(); stby_light = 1'b0; clk_run = 1'b1;
        cyc(4);
        chk("R6 pulse lost flag", nmi_flag, 1'b0);
        chk("R6 no req", nmi_req, 1'b0);

        // R7: light standby, masked, held level detected at clock restart
        drv(); stby_light = 1'b1; clk_run = 1'b0;
        drv(); nmi_pin = 1'b0;
        cyc(5);
        chk("R7 flag frozen in standby", nmi_flag, 1'b0);
        drv(); stby_light = 1'b0; clk_run = 1'b1;
        cyc(1);
        chk("R7 held edge detected", nmi_flag, 1'b1);
        chk("R7 req masked", nmi_req, 1'b0);
        write_mask(1'b0);
        #1;
        chk("R7 req after unmask", nmi_req, 1'b1);
        clear_flag();
        drv(); nmi_pin = 1'b1;
        cyc(5);

        // R8: deep standby ignores mask
        write_mask(1'b1);
        drv(); stby_deep = 1'b1; clk_run = 1'b0;
        drv(); nmi_pin = 1'b0;
        cyc(4);
        chk("R8 wake_deep with mask", wake_deep, 1'b1);
        chk("R8 no light wake", wake_light, 1'b0);
        drv(); nmi_pin = 1'b1;
        cyc(3);
        chk("R8 wake_deep held", wake_deep, 1'b1);
        drv(); stby_deep = 1'b0; clk_run = 1'b1;
        cyc(1);
        chk("R8 wake_deep cleared", wake_deep, 1'b0);

        // R9: mask write then power-on reset
        write_mask(1'b0);
        #1;
        chk("R9 mask written", nmi_mask, 1'b0);
        do_reset();
        cyc(1);
        chk("R9 mask after reset", nmi_mask, 1'b1);
        chk("R1 flag after reset", nmi_flag, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule